// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Controller

This block generates one pulse-width-modulated output from three word-wide registers reached over a simple 32-bit read/write bus: a control word, a duty word and a period word. A selected clock-enable pulse train is divided by a programmable prescaler. Each resulting tick advances a period counter. The output is high while the counter is below the duty value. One full period lasts the period value plus two ticks. Duty and period updates are held in shadow copies and applied only when a period ends, so a running waveform never shows a shortened or mixed cycle.

Counting can be told to pause while the system reports a doze, wait or debug condition. For each of these conditions a control bit lets counting go on. The controller is a three-state machine. ST_OFF is the disabled state. ST_RUN is counting. ST_HOLD is paused by a low-power or debug condition. The transitions are: enable (ST_OFF to ST_RUN), enable-while-halted (ST_OFF to ST_HOLD), halt (ST_RUN to ST_HOLD), resume (ST_HOLD to ST_RUN) and disable (any state to ST_OFF).

The next state is always worked out from the registered control word and the live condition inputs. The state register, counter and prescaler all update together on that decision.

Top module: `pwmc_top`

## Requirements
- R1: After reset all three registers read zero, the state is ST_OFF, the counter is zero and `pwm_out` is low.
- R2: Register word offsets are: control at 0x00, duty at 0x0C and period at 0x10. Duty and period keep bits 15:0. Control keeps bit 0 (enable), bits 15:4 (prescaler), bits 17:16 (source), bit 22 (debug-run), bit 23 (wait-run) and bit 24 (doze-run), which gives a read mask of 0x01C3FFF1. Unkept bits read zero. Any other offset reads zero, and writes to it change nothing.
- R3: With a prescaler field of p, the period counter advances once for every p+1 selected enable pulses. A field of 0 divides by 1.
- R4: One output period lasts exactly (period value + 2) counter ticks.
- R5: In each period the output is high for the first min(duty, period+2) ticks and low for the rest. A duty of 0 keeps it low. A duty above period+1 keeps it high.
- R6: Source field value 1 counts `clk_en_norm` pulses and value 2 counts `clk_en_fast` pulses. Values 0 and 3 count nothing, so the counter holds.
- R7: While `sys_doze`, `sys_wait` or `sys_dbg` is high and its matching run bit is clear, the block is in ST_HOLD and the counter, prescaler and output hold their values.
- R8: A new duty or period value takes effect only when the counter rolls over to zero, or while the block is disabled.
- R9: When the enable bit is clear, the block goes to ST_OFF on the next clock. The counter and prescaler clear, the output stays low, and counting starts again from zero on re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Contents of the addressed register (combinational) |
| clk_en_norm | input | 1 | Normal-rate counting enable pulse |
| clk_en_fast | input | 1 | High-rate counting enable pulse |
| sys_doze | input | 1 | System is in doze |
| sys_wait | input | 1 | System is in wait |
| sys_dbg | input | 1 | System is halted for debug |
| pwm_out | output | 1 | Modulated output |

## Verification
Two events can land on the same clock edge: a bus write to the duty or period word, and the tick that rolls the counter over and loads the shadow copies. The outcome then depends on whether the old or the new register value is captured. The random phase writes small duty and period values at random moments while the counter wraps every few ticks, so such collisions occur often. A cycle-level bench model, built from the requirements, judges every output cycle. A directed case writes a new duty value right after a period starts and counts the high cycles of that period and of the next one.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int PSC_W = 12;
    localparam int SRC_W = 2;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_DUTY   = 8'h0C;
    localparam logic [7:0] OFF_PERIOD = 8'h10;

    localparam int BIT_EN       = 0;
    localparam int BIT_PSC_LO   = 4;
    localparam int BIT_SRC_LO   = 16;
    localparam int BIT_RUN_DBG  = 22;
    localparam int BIT_RUN_WAIT = 23;
    localparam int BIT_RUN_DOZE = 24;

    localparam logic [SRC_W-1:0] SRC_NORM = 2'd1;
    localparam logic [SRC_W-1:0] SRC_FAST = 2'd2;

    typedef struct packed {
        logic             run_doze;
        logic             run_wait;
        logic             run_dbg;
        logic [SRC_W-1:0] src;
        logic [PSC_W-1:0] psc;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pwm_state_t;

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  duty_q,
    output logic [CNT_W-1:0]  period_q
);

    localparam int PSC_HI = BIT_PSC_LO + PSC_W - 1;
    localparam int SRC_HI = BIT_SRC_LO + SRC_W - 1;

    logic hit_ctrl, hit_duty, hit_period, do_wr;

    assign hit_ctrl   = (bus_addr == OFF_CTRL[ADDR_W-1:0]);
    assign hit_duty   = (bus_addr == OFF_DUTY[ADDR_W-1:0]);
    assign hit_period = (bus_addr == OFF_PERIOD[ADDR_W-1:0]);
    assign do_wr      = bus_sel && bus_wr;

    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:BIT_RUN_DOZE+1],
                            bus_wdata[BIT_RUN_DBG-1:SRC_HI+1],
                            bus_wdata[BIT_PSC_LO-1:BIT_EN+1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            duty_q   <= '0;
            period_q <= '0;
        end else if (do_wr) begin
            if (hit_ctrl) begin
                ctrl_q.en       <= bus_wdata[BIT_EN];
                ctrl_q.psc      <= bus_wdata[PSC_HI:BIT_PSC_LO];
                ctrl_q.src      <= bus_wdata[SRC_HI:BIT_SRC_LO];
                ctrl_q.run_dbg  <= bus_wdata[BIT_RUN_DBG];
                ctrl_q.run_wait <= bus_wdata[BIT_RUN_WAIT];
                ctrl_q.run_doze <= bus_wdata[BIT_RUN_DOZE];
            end
            if (hit_duty)   duty_q   <= bus_wdata[CNT_W-1:0];
            if (hit_period) period_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[BIT_EN]                 = ctrl_q.en;
            bus_rdata[PSC_HI:BIT_PSC_LO]      = ctrl_q.psc;
            bus_rdata[SRC_HI:BIT_SRC_LO]      = ctrl_q.src;
            bus_rdata[BIT_RUN_DBG]            = ctrl_q.run_dbg;
            bus_rdata[BIT_RUN_WAIT]           = ctrl_q.run_wait;
            bus_rdata[BIT_RUN_DOZE]           = ctrl_q.run_doze;
        end else if (hit_duty) begin
            bus_rdata[CNT_W-1:0] = duty_q;
        end else if (hit_period) begin
            bus_rdata[CNT_W-1:0] = period_q;
        end
    end

endmodule

// File: rtl/pwmc_tick.sv
module pwmc_tick
    import pwmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [PSC_W-1:0] psc,
    input  logic             en_norm,
    input  logic             en_fast,
    input  logic             clear,
    input  logic             go,
    output logic             tick
);

    logic [PSC_W-1:0] pre_q;
    logic             pulse;
    logic             at_end;

    always_comb begin
        unique case (src_sel)
            SRC_NORM: pulse = en_norm;
            SRC_FAST: pulse = en_fast;
            default:  pulse = 1'b0;
        endcase
    end

    assign at_end = (pre_q >= psc);
    assign tick   = go && pulse && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else if (go && pulse) begin
            if (at_end) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwmc_core.sv
module pwmc_core
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_en,
    input  logic             run_doze,
    input  logic             run_wait,
    input  logic             run_dbg,
    input  logic             sys_doze,
    input  logic             sys_wait,
    input  logic             sys_dbg,
    input  logic             tick,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] period,
    output logic             clear,
    output logic             go,
    output logic             pwm_out,
    output pwm_state_t       state_q,
    output logic [CNT_W:0]   cnt_q,
    output logic [CNT_W-1:0] duty_sh,
    output logic [CNT_W-1:0] period_sh
);

    pwm_state_t     state_d;
    logic           halt;
    logic [CNT_W:0] last_cnt;

    assign halt = (sys_doze && !run_doze) ||
                  (sys_wait && !run_wait) ||
                  (sys_dbg  && !run_dbg);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_en) state_d = halt ? ST_HOLD : ST_RUN;
            end
            ST_RUN: begin
                if (!ctrl_en)  state_d = ST_OFF;
                else if (halt) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!ctrl_en)  state_d = ST_OFF;
                else if (!halt) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign clear    = (state_d == ST_OFF);
    assign go       = (state_d == ST_RUN);
    assign last_cnt = {1'b0, period_sh} + 1'b1;

    // period counter and shadow copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            duty_sh   <= '0;
            period_sh <= '0;
        end else if (clear) begin
            cnt_q     <= '0;
            duty_sh   <= duty;
            period_sh <= period;
        end else if (tick) begin
            if (cnt_q == last_cnt) begin
                cnt_q     <= '0;
                duty_sh   <= duty;
                period_sh <= period;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_HOLD: pwm_out = (cnt_q < {1'b0, duty_sh});
            default:         pwm_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              clk_en_norm,
    input  logic              clk_en_fast,
    input  logic              sys_doze,
    input  logic              sys_wait,
    input  logic              sys_dbg,
    output logic              pwm_out
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] duty_q, period_q;
    logic [CNT_W-1:0] duty_sh, period_sh;
    logic [CNT_W:0]   cnt_q;
    pwm_state_t       state_q;
    logic             tick, clear, go;

    pwmc_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ctrl_q   (ctrl_q),
        .duty_q   (duty_q),
        .period_q (period_q)
    );

    pwmc_tick u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_sel(ctrl_q.src),
        .psc    (ctrl_q.psc),
        .en_norm(clk_en_norm),
        .en_fast(clk_en_fast),
        .clear  (clear),
        .go     (go),
        .tick   (tick)
    );

    pwmc_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_q.en),
        .run_doze (ctrl_q.run_doze),
        .run_wait (ctrl_q.run_wait),
        .run_dbg  (ctrl_q.run_dbg),
        .sys_doze (sys_doze),
        .sys_wait (sys_wait),
        .sys_dbg  (sys_dbg),
        .tick     (tick),
        .duty     (duty_q),
        .period   (period_q),
        .clear    (clear),
        .go       (go),
        .pwm_out  (pwm_out),
        .state_q  (state_q),
        .cnt_q    (cnt_q),
        .duty_sh  (duty_sh),
        .period_sh(period_sh)
    );

endmodule

// File: rtl/pwmc_chk.sv
module pwmc_chk
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input ctrl_t            ctrl_q,
    input pwm_state_t       state_q,
    input logic [CNT_W:0]   cnt_q,
    input logic [CNT_W-1:0] duty_sh,
    input logic [CNT_W-1:0] period_sh,
    input logic             sys_doze,
    input logic             sys_wait,
    input logic             sys_dbg,
    input logic             pwm_out
);

    logic [CNT_W:0] lim;
    logic           held, nosrc;
    assign lim   = {1'b0, period_sh} + 1'b1;
    assign held  = (sys_doze && !ctrl_q.run_doze) ||
                   (sys_wait && !ctrl_q.run_wait) ||
                   (sys_dbg  && !ctrl_q.run_dbg);
    assign nosrc = (ctrl_q.src == 2'd0) || (ctrl_q.src == 2'd3);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == ST_OFF && cnt_q == '0 && !pwm_out));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);

    p_duty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sh == '0) |-> !pwm_out);

    p_duty_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && {1'b0, duty_sh} > lim) |-> pwm_out);

    p_no_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && nosrc) |=> (cnt_q == $past(cnt_q)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && held) |=> (cnt_q == $past(cnt_q) && state_q == ST_HOLD));

    p_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(duty_sh) || !$stable(period_sh)) |-> (cnt_q == '0));

    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (!pwm_out && cnt_q == '0));

endmodule

bind pwmc_top pwmc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_q   (ctrl_q),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .duty_sh  (duty_sh),
    .period_sh(period_sh),
    .sys_doze (sys_doze),
    .sys_wait (sys_wait),
    .sys_dbg  (sys_dbg),
    .pwm_out  (pwm_out)
);

// File: tb/sim_pwmc_top.sv
`timescale 1ns/1ps
module sim_pwmc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        clk_en_norm = 1'b0, clk_en_fast = 1'b0;
    logic        sys_doze = 1'b0, sys_wait = 1'b0, sys_dbg = 1'b0;
    logic        pwm_out;

    always #10 clk = ~clk;

    pwmc_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_en_norm(clk_en_norm), .clk_en_fast(clk_en_fast),
        .sys_doze(sys_doze), .sys_wait(sys_wait), .sys_dbg(sys_dbg),
        .pwm_out(pwm_out)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // enable-pulse pattern: 0 low, 1 high, 2 alternate, 3 random
    int norm_pat = 0, fast_pat = 0;
    bit tgl = 1'b0;
    always @(negedge clk) begin
        tgl <= ~tgl;
        clk_en_norm <= (norm_pat == 1) || (norm_pat == 2 && tgl) || (norm_pat == 3 && $urandom_range(1) == 1);
        clk_en_fast <= (fast_pat == 1) || (fast_pat == 2 && tgl) || (fast_pat == 3 && $urandom_range(1) == 1);
    end

    // ---------------- reference model from the requirements ----------------
    localparam logic [31:0] CTRL_MASK = 32'h01C3_FFF1;
    logic [31:0] m_ctrl = '0;
    logic [15:0] m_duty = '0, m_per = '0, m_duty_sh = '0, m_per_sh = '0;
    logic [16:0] m_cnt = '0;
    logic [11:0] m_pre = '0;
    bit          m_on = 1'b0;

    function automatic logic [31:0] m_read(logic [4:0] a);
        if (a == 5'h00) return m_ctrl;
        if (a == 5'h0C) return {16'h0, m_duty};
        if (a == 5'h10) return {16'h0, m_per};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_duty = '0; m_per = '0; m_duty_sh = '0; m_per_sh = '0;
            m_cnt = '0; m_pre = '0; m_on = 1'b0;
        end else begin
            bit hlt, pls;
            hlt = (sys_doze && !m_ctrl[24]) || (sys_wait && !m_ctrl[23]) || (sys_dbg && !m_ctrl[22]);
            pls = (m_ctrl[17:16] == 2'd1) ? clk_en_norm : (m_ctrl[17:16] == 2'd2) ? clk_en_fast : 1'b0;
            if (!m_ctrl[0]) begin
                m_on = 1'b0; m_cnt = '0; m_pre = '0; m_duty_sh = m_duty; m_per_sh = m_per;
            end else begin
                m_on = 1'b1;
                if (!hlt && pls) begin
                    if (m_pre >= m_ctrl[15:4]) begin
                        m_pre = '0;
                        if (m_cnt == {1'b0, m_per_sh} + 17'd1) begin
                            m_cnt = '0; m_duty_sh = m_duty; m_per_sh = m_per;
                        end else m_cnt = m_cnt + 17'd1;
                    end else m_pre = m_pre + 12'd1;
                end
            end
            if (bus_sel && bus_wr) begin
                if (bus_addr == 5'h00) m_ctrl = bus_wdata & CTRL_MASK;
                if (bus_addr == 5'h0C) m_duty = bus_wdata[15:0];
                if (bus_addr == 5'h10) m_per  = bus_wdata[15:0];
            end
        end
    end

    // every output cycle against the model (R3, R4, R5, R6, R7, R8, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_o;
            exp_o = m_on && (m_cnt < {1'b0, m_duty_sh});
            check(pwm_out == exp_o, "R5 model output", pwm_out, exp_o);
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic high_count(int n, output int hc);
        hc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hc++;
        end
    endtask

    function automatic logic [31:0] mk_ctrl(bit en, int psc, int src, bit rdz, bit rwt, bit rdb);
        return {7'h0, rdz, rwt, rdb, 4'h0, src[1:0], psc[11:0], 3'h0, en};
    endfunction

    initial begin
        logic [31:0] d;
        int hc, sd;
        sd = $urandom(32'h5eed_0042);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, d); check(d == 0, "R1 ctrl after reset", d, 0);
        rd(5'h0C, d); check(d == 0, "R1 duty after reset", d, 0);
        rd(5'h10, d); check(d == 0, "R1 period after reset", d, 0);
        check(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);

        // R2 register map and masks
        wr(5'h00, 32'hFFFF_FFFE);
        rd(5'h00, d); check(d == 32'h01C3_FFF0, "R2 ctrl mask", d, 32'h01C3_FFF0);
        wr(5'h0C, 32'hABCD_1234);
        rd(5'h0C, d); check(d == 32'h1234, "R2 duty mask", d, 32'h1234);
        wr(5'h10, 32'h5A5A_00C7);
        rd(5'h10, d); check(d == 32'h00C7, "R2 period mask", d, 32'h00C7);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, d); check(d == 0, "R2 unmapped read", d, 0);
        rd(5'h0C, d); check(d == 32'h1234, "R2 unmapped write ignored", d, 32'h1234);
        wr(5'h00, 32'h0);

        // R4 R5: period 5 -> 7 ticks, duty 3, divide by 1
        norm_pat = 1;
        wr(5'h10, 5); wr(5'h0C, 3);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0));
        repeat (4) @(negedge clk);
        high_count(70, hc); check(hc == 30, "R4 R5 high cycles period7 duty3", hc, 30);

        // R3: prescaler field 2 -> 21 cycles per period, 9 high
        wr(5'h00, 32'h0);
        wr(5'h00, mk_ctrl(1, 2, 1, 0, 0, 0));
        repeat (4) @(negedge clk);
        high_count(210, hc); check(hc == 90, "R3 prescaled high cycles", hc, 90);

        // R5 duty zero and duty above period+1
        wr(5'h00, 32'h0); wr(5'h0C, 0);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0));
        repeat (4) @(negedge clk);
        high_count(70, hc); check(hc == 0, "R5 duty zero stays low", hc, 0);
        wr(5'h00, 32'h0); wr(5'h0C, 7);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0));
        repeat (4) @(negedge clk);
        high_count(70, hc); check(hc == 70, "R5 duty over period stays high", hc, 70);

        // R6 source select
        wr(5'h00, 32'h0); wr(5'h0C, 3);
        norm_pat = 1; fast_pat = 2;
        wr(5'h00, mk_ctrl(1, 0, 2, 0, 0, 0));
        repeat (4) @(negedge clk);
        high_count(140, hc); check(hc == 60, "R6 fast source half rate", hc, 60);
        wr(5'h00, mk_ctrl(1, 0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        high_count(100, hc); check(hc == 0 || hc == 100, "R6 source 0 frozen", hc, 0);
        wr(5'h00, mk_ctrl(1, 0, 3, 0, 0, 0));
        repeat (2) @(negedge clk);
        high_count(100, hc); check(hc == 0 || hc == 100, "R6 source 3 frozen", hc, 0);

        // R7 low-power hold and run bits
        wr(5'h00, 32'h0);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0));
        repeat (5) @(negedge clk);
        sys_doze = 1'b1;
        repeat (2) @(negedge clk);
        high_count(100, hc); check(hc == 0 || hc == 100, "R7 doze holds", hc, 0);
        wr(5'h00, mk_ctrl(1, 0, 1, 1, 0, 0));
        repeat (2) @(negedge clk);
        high_count(70, hc); check(hc == 30, "R7 doze-run counts", hc, 30);
        sys_doze = 1'b0; sys_dbg = 1'b1;
        repeat (2) @(negedge clk);
        high_count(100, hc); check(hc == 0 || hc == 100, "R7 debug holds", hc, 0);
        sys_dbg = 1'b0;

        // R8 duty change applies at rollover: period 9 -> 11 ticks
        wr(5'h00, 32'h0); wr(5'h10, 9); wr(5'h0C, 2);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0));
        repeat (3) @(negedge clk);
        begin
            bit prev;
            prev = pwm_out;
            forever begin
                @(negedge clk);
                if (pwm_out && !prev) break;
                prev = pwm_out;
            end
        end
        hc = 1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 8;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            if (pwm_out) hc++;
        end
        check(hc == 2, "R8 current period keeps old duty", hc, 2);
        high_count(11, hc); check(hc == 8, "R8 next period uses new duty", hc, 8);

        // R9 disable forces low and restarts from zero
        wr(5'h00, 32'h0);
        @(negedge clk);
        high_count(50, hc); check(hc == 0, "R9 disabled stays low", hc, 0);
        wr(5'h00, mk_ctrl(1, 0, 1, 0, 0, 0));
        high_count(11, hc); check(hc == 8, "R9 restart from zero", hc, 8);

        // random phase, judged cycle by cycle by the model
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            norm_pat = 3; fast_pat = 3;
            sys_doze = ($urandom_range(7) == 0);
            sys_wait = ($urandom_range(7) == 0);
            sys_dbg  = ($urandom_range(15) == 0);
            if ($urandom_range(11) == 0) begin
                int r;
                r = $urandom_range(3);
                bus_sel = 1'b1; bus_wr = 1'b1;
                case (r)
                    0: begin
                        bus_addr = 5'h00;
                        bus_wdata = mk_ctrl($urandom_range(7) != 0, $urandom_range(3), $urandom_range(3),
                                            $urandom_range(1), $urandom_range(1), $urandom_range(1))
                                    | ($urandom() & ~CTRL_MASK);
                    end
                    1: begin bus_addr = 5'h0C; bus_wdata = $urandom_range(13); end
                    2: begin bus_addr = 5'h10; bus_wdata = $urandom_range(11); end
                    default: begin bus_addr = 5'h08; bus_wdata = $urandom(); end
                endcase
            end else if ($urandom_range(7) == 0) begin
                logic [4:0] a;
                a = ($urandom_range(3) == 0) ? 5'h00 : ($urandom_range(1) == 0) ? 5'h0C : 5'h10;
                bus_addr = a;
                #2 check(bus_rdata == m_read(a), "R2 random readback", bus_rdata, m_read(a));
            end
        end

        @(negedge clk);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule